// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of data words by a fixed number of stages. A chain of flip-flops would move every sample on every clock. Here the samples sit still in a small simple dual-port memory with one write port and one read port. Only two address counters move. This keeps long delays cheap in area. The delay is set at build time through the address width, so the number of stages is always a power of two.

On an enabled clock edge, the incoming word is written at the write address and the word at the read address is loaded into an output register. Both addresses then advance by one. Reset puts the read address at the first entry and the write address at the last entry. The write address therefore always trails the read address by one. The read and the write never target the same entry, so no read-during-write rule is needed.

From the outside the block behaves exactly like a chain of `DEPTH` registers that all share one clock enable. A flag marks when the output holds real data and no longer holds leftover memory contents.

Top module: `ram_delay_line`

## Requirements
- R1: While reset is high, and on the first sampling point after it is released, `dout_valid` is 0.
- R2: A word sampled on an enabled edge appears on `dout` right after the `DEPTH`-th enabled edge, counting its own capture edge as the first. This matches a chain of `DEPTH` registers with a common enable. `DEPTH` is `2**AW`.
- R3: Words leave in the order they entered, with no loss or repetition, across any number of trips around the memory.
- R4: With `en` low, `dout` and `dout_valid` hold their values and `din` is ignored. The word present on `din` during a disabled cycle never reaches `dout`.
- R5: `dout_valid` rises on the `DEPTH`-th enabled edge after reset and stays high until the next reset.
- R6: A reset in mid-stream drops `dout_valid` and discards all earlier words. The next valid word is the first word sampled after that reset.
- R7: Reset sets the read address to entry 0 and the write address to the last entry. Each enabled edge advances both addresses by one, wrapping from the last entry back to 0.
- R8: The write address always equals the read address minus one, modulo `DEPTH`, so a read and a write never meet at the same entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low the line is frozen |
| din | input | DW | Incoming data word |
| dout | output | DW | Word delayed by `DEPTH` enabled stages |
| dout_valid | output | 1 | High once `dout` carries a real sample |

## Verification
The hardest case to reach from the ports is a memory entry that is read after it has been written more than once. Entries are reused only on the second and later laps of the address counters. The stimulus therefore runs a long stream of distinct words, several times longer than the depth, and scatters disabled cycles through it. During those disabled cycles `din` changes, so that a freeze that is not clean would show up as a stray or shifted word. A reset in mid-stream, with `en` held high through it, then checks that the output flag and the address counters restart cleanly.

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_valid
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;

  always_ff @(posedge clk)
    if (en && !rst) mem[wr_ptr] <= din;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr     <= '0;
      wr_ptr     <= '1;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else if (en) begin
      rd_ptr <= rd_ptr + AW'(1);
      wr_ptr <= wr_ptr + AW'(1);
      dout   <= mem[rd_ptr];
      if (rd_ptr == '1) dout_valid <= 1'b1;
    end
  end

  // pointers never coincide: write always trails read by one entry
  assert_ptr_gap_R8: assert property (@(posedge clk) disable iff (rst)
    wr_ptr == rd_ptr - AW'(1));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    en |=> rd_ptr == $past(rd_ptr) + AW'(1));

  assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout) && $stable(dout_valid) && $stable(rd_ptr));

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> dout_valid);

endmodule

// File: tb/tb_ram_delay_line.sv
module tb_ram_delay_line;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, en;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic dout_valid;

  always #5 clk = ~clk;

  ram_delay_line #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .en(en), .din(din),
    .dout(dout), .dout_valid(dout_valid)
  );

  // {en, din}
  localparam logic [8:0] VEC [24] = '{
    9'h111, 9'h122, 9'h133, 9'h0EE, 9'h144, 9'h155, 9'h166, 9'h177,
    9'h0DD, 9'h0CC, 9'h188, 9'h199, 9'h1AA, 9'h1BB, 9'h0FF, 9'h1C1,
    9'h1C2, 9'h1C3, 9'h1C4, 9'h0AB, 9'h1C5, 9'h1C6, 9'h1C7, 9'h1C8
  };

  int checks = 0, failures = 0;
  int n_en = 0;
  logic [DW-1:0] hist [0:1023];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    bit ev = (n_en >= DEPTH);
    chk(dout_valid == ev, {req, "/R5 valid"}, 32'(dout_valid), 32'(ev));
    if (ev) chk(dout == hist[n_en-DEPTH], {req, "/R2 data"}, 32'(dout), 32'(hist[n_en-DEPTH]));
  endtask

  task automatic step(input logic e, input logic [DW-1:0] d, input string req);
    logic [DW-1:0] pd = dout;
    logic pv = dout_valid;
    en = e; din = d;
    @(posedge clk);
    @(negedge clk);
    if (e) begin hist[n_en] = d; n_en++; end
    else begin
      chk(dout == pd && dout_valid == pv, "R4 frozen", 32'({pv, dout}), 32'({pv, pd}));
    end
    check_out(req);
  endtask

  task automatic do_reset(input logic hold_en);
    rst = 1'b1; en = hold_en; din = 8'h5A;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dout_valid == 1'b0, "R1 valid low in reset", 32'(dout_valid), 0);
    rst = 1'b0;
    n_en = 0;
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; din = '0;
    @(negedge clk);
    do_reset(1'b0);
    chk(dout_valid == 1'b0, "R1 after release", 32'(dout_valid), 0);

    for (int i = 0; i < 24; i++) step(VEC[i][8], VEC[i][7:0], "R2 table");

    // long stream with scattered stalls: several laps (R3)
    for (int i = 0; i < 5*DEPTH; i++) begin
      step(1'b1, 8'(i*7 + 3), "R3 wrap");
      if (i % 5 == 2) step(1'b0, 8'(8'hF0 ^ i), "R4 stall");
    end

    // long freeze with toggling input
    for (int i = 0; i < 6; i++) step(1'b0, 8'(i * 31), "R4 freeze");

    // mid-stream reset with en held high (R6)
    do_reset(1'b1);
    for (int i = 0; i < 2*DEPTH + 3; i++) step(1'b1, 8'(8'h80 + i), "R6 restart");
    for (int i = 0; i < 2*DEPTH; i++) step(i[0], 8'(8'h40 + i), "R7 alt enable");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule